// File: doc/BRIEF.md
# Interleaving Switching-Clock Generator

This block makes the switching clock of a PWM controller. A phase counter, clocked by the system clock, runs a free period that software sets through `periodCfg`. At a 125 MHz system clock the value 500 gives 250 kHz, and the value 125 gives 1 MHz. Each time the period restarts, `swClk` goes high for one system-clock cycle. Half a period later the unit drives a fixed-width pulse on `syncOut`, so a second unit can switch in anti-phase.

The unit also watches a shared sync line on `syncIn`. The line passes through a flop synchronizer and an edge detector. A rising edge that arrives before the local period runs out comes from a faster source. That edge restarts the local phase, and the unit becomes a slave, which `isSlave` reports. From then on every sync edge restarts the clock. A slave never drives `syncOut`, so two units can share one line without contention. Because the master's sync pulse sits half a period after the master's own clock, the slave switches half a period behind the master.

If no sync edge arrives for a local period plus a margin, the slave returns to free-running master mode. While the unit drives its own sync pulse, it ignores edges on its input for that pulse and the synchronizer delay after it. This stops the unit from locking onto its own pulse when the line loops back to it.

Top module: `swsync_unit`

## Requirements
- R1: While `rstN` is low and right after reset, `swClk`, `syncOut` and `isSlave` are all 0.
- R2: In master mode with `syncIn` low and `periodCfg` = P (P >= 4), `swClk` is a one-cycle pulse. It is first high in the cycle after the P-th rising clock edge after reset release, and then every P cycles. P = 500 is the 250 kHz default at 125 MHz.
- R3: In master mode, `syncOut` rises floor(P/2) cycles after each `swClk` pulse begins.
- R4: Each `syncOut` pulse stays high for exactly PULSE_CYC cycles. The default is 14, about 110 ns at 125 MHz.
- R5: Suppose a rising edge on `syncIn` is first sampled high at clock edge k, while the unit is a master and outside its echo guard. Then `swClk` is high in the cycle after edge k+SYNC_STAGES, and `isSlave` is 1 from that same cycle.
- R6: While `isSlave` is 1, `syncOut` stays 0.
- R7: In slave mode, each rising `syncIn` edge produces exactly one `swClk` pulse, with the latency of R5. No local pulse appears between edges spaced less than P+LOSS_MARGIN cycles apart.
- R8: In slave mode, suppose no sync edge arrives within P+LOSS_MARGIN cycles of the last `swClk` pulse. Then `swClk` pulses at that point, `isSlave` returns to 0 in the same cycle, and R2 and R3 behaviour resumes.
- R9: A master ignores rising `syncIn` edges that are sampled during its own `syncOut` pulse and for the following SYNC_STAGES+1 cycles. With `syncIn` tied to `syncOut`, the unit stays master with period P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| periodCfg | input | CNT_W | Free-running switching period in system-clock cycles |
| syncIn | input | 1 | Shared sync line, asynchronous |
| swClk | output | 1 | One-cycle switching clock pulse |
| syncOut | output | 1 | Half-period sync pulse, driven only as master |
| isSlave | output | 1 | 1 while locked to an external faster source |

## Verification
The bench aims at the exact cycle counts, because an off-by-one compare in the phase counter would stretch the period by one cycle or move the sync pulse off its half-period point. It checks slave entry and slave following at a fixed latency. A design that kept its local wrap in slave mode would emit extra clocks between sync edges, and one that kept driving the line would contend with the master. It times the fallback from slave to master against P+LOSS_MARGIN. It also loops `syncOut` back into `syncIn`: a design without the echo guard would slave itself to its own pulse and halve its period.

// File: rtl/swsync_pkg.sv
package swsync_pkg;

  typedef enum logic {
    MODE_MASTER = 1'b0,
    MODE_SLAVE  = 1'b1
  } syncMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;    // zero the phase counter and fire swClk
    logic armPulse;   // load the sync output pulse counter
    logic slaveMode;  // current mode, gates syncOut
  } ctrlStrobe_t;

  // compare results from datapath to control
  typedef struct packed {
    logic atWrap;     // phase reached the last index of the period
    logic atHalf;     // phase one cycle before the half point
    logic atLoss;     // phase reached period plus loss margin
    logic echoBusy;   // own pulse or its echo window active
  } dpathFlag_t;

endpackage

// File: rtl/swsync_edge.sv
module swsync_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic syncIn,
  output logic syncRise
);

  // SYNC_STAGES synchronizer flops plus one history flop for edge detect
  logic [SYNC_STAGES:0] syncPipe;

  generate
    genvar gi;
    for (gi = 0; gi <= SYNC_STAGES; gi++) begin : g_stage
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncPipe[gi] <= 1'b0;
          else       syncPipe[gi] <= syncIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncPipe[gi] <= 1'b0;
          else       syncPipe[gi] <= syncPipe[gi-1];
        end
      end
    end
  endgenerate

  assign syncRise = syncPipe[SYNC_STAGES-1] & ~syncPipe[SYNC_STAGES];

  // an edge lasts exactly one cycle
  p_rise_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    syncRise |=> !syncRise);

endmodule

// File: rtl/swsync_ctrl.sv
module swsync_ctrl
  import swsync_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        syncRise,
  input  dpathFlag_t  flags,
  output ctrlStrobe_t strobe,
  output logic        slaveFlag
);

  syncMode_e mode, modeNext;
  logic      acceptEdge;

  // a master skips edges inside its own pulse/echo window; a slave takes all
  assign acceptEdge = syncRise & ((mode == MODE_SLAVE) | ~flags.echoBusy);

  always_comb begin
    modeNext = mode;
    if (acceptEdge)
      modeNext = MODE_SLAVE;
    else if ((mode == MODE_SLAVE) && flags.atLoss)
      modeNext = MODE_MASTER;
  end

  always_comb begin
    strobe.restart   = acceptEdge
                     | ((mode == MODE_MASTER) & flags.atWrap)
                     | ((mode == MODE_SLAVE)  & flags.atLoss);
    strobe.armPulse  = (mode == MODE_MASTER) & flags.atHalf & ~acceptEdge;
    strobe.slaveMode = (mode == MODE_SLAVE);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) mode <= MODE_MASTER;
    else       mode <= modeNext;
  end

  assign slaveFlag = (mode == MODE_SLAVE);

  // own echo must never hand control away
  p_echo_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    ((mode == MODE_MASTER) && flags.echoBusy) |=> (mode == MODE_MASTER));

endmodule

// File: rtl/swsync_dpath.sv
module swsync_dpath
  import swsync_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PULSE_CYC   = 14,
  parameter int GUARD_CYC   = 3,
  parameter int LOSS_MARGIN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodCfg,
  input  ctrlStrobe_t      strobe,
  output dpathFlag_t       flags,
  output logic             swClk,
  output logic             syncOut
);

  localparam int CW       = CNT_W + 1;
  localparam int PW_TOTAL = PULSE_CYC + GUARD_CYC;
  localparam int PW_W     = $clog2(PW_TOTAL + 1);
  localparam logic [PW_W-1:0] PW_LOAD  = PW_W'(PW_TOTAL);
  localparam logic [PW_W-1:0] PW_GUARD = PW_W'(GUARD_CYC);

  logic [CW-1:0]   phaseCnt;
  logic [CW-1:0]   perExt, lastIdx, halfIdx, lossIdx;
  logic [PW_W-1:0] pwCnt;
  logic            swClkQ;

  assign perExt  = {1'b0, periodCfg};
  assign lastIdx = perExt - CW'(1);
  assign halfIdx = (perExt >> 1) - CW'(1);
  assign lossIdx = lastIdx + CW'(LOSS_MARGIN);

  // phase counter, saturating at all ones
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      phaseCnt <= '0;
    else if (strobe.restart)
      phaseCnt <= '0;
    else if (phaseCnt != '1)
      phaseCnt <= phaseCnt + CW'(1);
  end

  always_comb begin
    flags.atWrap   = (phaseCnt >= lastIdx);
    flags.atHalf   = (phaseCnt == halfIdx);
    flags.atLoss   = (phaseCnt >= lossIdx);
    flags.echoBusy = (pwCnt != '0);
  end

  // sync pulse: PULSE_CYC cycles driven, then GUARD_CYC cycles of echo guard
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      pwCnt <= '0;
    else if (strobe.armPulse)
      pwCnt <= PW_LOAD;
    else if (pwCnt != '0)
      pwCnt <= pwCnt - PW_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) swClkQ <= 1'b0;
    else       swClkQ <= strobe.restart;
  end

  assign swClk   = swClkQ;
  assign syncOut = ~strobe.slaveMode & (pwCnt > PW_GUARD);

  // the clock pulse coincides with phase zero
  p_clk_at_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    swClkQ |-> (phaseCnt == '0));

  // a sync pulse is never a single-cycle glitch
  p_pulse_body_r4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(syncOut) && !strobe.slaveMode) |=> (syncOut || strobe.slaveMode));

endmodule

// File: rtl/swsync_unit.sv
module swsync_unit
  import swsync_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PULSE_CYC   = 14,
  parameter int SYNC_STAGES = 2,
  parameter int LOSS_MARGIN = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] periodCfg,
  input  logic             syncIn,
  output logic             swClk,
  output logic             syncOut,
  output logic             isSlave
);

  localparam int GUARD_CYC = SYNC_STAGES + 1;

  logic        syncRise;
  ctrlStrobe_t strobe;
  dpathFlag_t  flags;

  swsync_edge #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_edge (
    .clk      (clk),
    .rstN     (rstN),
    .syncIn   (syncIn),
    .syncRise (syncRise)
  );

  swsync_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .syncRise  (syncRise),
    .flags     (flags),
    .strobe    (strobe),
    .slaveFlag (isSlave)
  );

  swsync_dpath #(
    .CNT_W       (CNT_W),
    .PULSE_CYC   (PULSE_CYC),
    .GUARD_CYC   (GUARD_CYC),
    .LOSS_MARGIN (LOSS_MARGIN)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .periodCfg (periodCfg),
    .strobe    (strobe),
    .flags     (flags),
    .swClk     (swClk),
    .syncOut   (syncOut)
  );

  p_one_cycle_clk_r2: assert property (@(posedge clk) disable iff (!rstN)
    swClk |=> !swClk);

  p_entry_clk_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(isSlave) |-> swClk);

  p_slave_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    isSlave |-> !syncOut);

  p_fallback_clk_r8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(isSlave) |-> swClk);

endmodule

// File: tb/swsync_unit_test.sv
`timescale 1ns/1ps
module swsync_unit_test;

  localparam int CNT_W = 16;
  localparam int PULSE = 14;
  localparam int STG   = 2;
  localparam int MARG  = 16;

  typedef struct packed {
    int per;
    int gap;
    int off;
  } vec_t;

  localparam int NVEC = 6;
  localparam vec_t VECS [NVEC] = '{
    '{32, 32, 16}, '{40, 40, 20}, '{57, 57, 28},
    '{64, 64, 32}, '{100, 100, 50}, '{500, 500, 250}
  };

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [CNT_W-1:0] periodCfg = 16'd100;
  logic             extSync = 1'b0;
  logic             loopBack = 1'b0;
  logic             syncLine;
  logic             swClk, syncOut, isSlave;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  int swCount = 0;
  int slaveDrive = 0;
  int t0 = 0;

  assign syncLine = loopBack ? syncOut : extSync;

  swsync_unit #(
    .CNT_W(CNT_W), .PULSE_CYC(PULSE), .SYNC_STAGES(STG), .LOSS_MARGIN(MARG)
  ) uut (
    .clk(clk), .rstN(rstN), .periodCfg(periodCfg), .syncIn(syncLine),
    .swClk(swClk), .syncOut(syncOut), .isSlave(isSlave)
  );

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rstN && swClk) swCount <= swCount + 1;
    if (rstN && isSlave && syncOut) slaveDrive <= slaveDrive + 1;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic doReset(input int p);
    @(negedge clk);
    rstN = 1'b0;
    periodCfg = CNT_W'(p);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    t0 = cyc;
  endtask

  task automatic waitSw(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (swClk) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic waitSyncRise(input int limit, output int at);
    at = -1;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (syncOut) begin
        at = cyc;
        break;
      end
    end
  endtask

  task automatic pulseWidth(output int w);
    w = 1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!syncOut) break;
      w++;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL R2 watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int a1, a2, rs, w, k, r, cnt0;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1", "swClk in reset", int'(swClk), 0);
    chk("R1", "syncOut in reset", int'(syncOut), 0);
    chk("R1", "isSlave in reset", int'(isSlave), 0);

    // table walk: free-run period, sync offset, pulse width
    for (int v = 0; v < NVEC; v++) begin
      doReset(VECS[v].per);
      waitSw(VECS[v].per + 8, a1);
      chk("R2", "first pulse delay", a1 - t0, VECS[v].per);
      waitSw(VECS[v].per + 8, a2);
      chk("R2", "period", a2 - a1, VECS[v].gap);
      waitSyncRise(VECS[v].per, rs);
      chk("R3", "sync offset", rs - a2, VECS[v].off);
      pulseWidth(w);
      chk("R4", "sync width", w, PULSE);
      chk("R2", "stays master", int'(isSlave), 0);
    end

    // R5: slave entry from a faster source
    doReset(100);
    waitSw(120, a1);
    repeat (20) @(negedge clk);
    extSync = 1'b1;
    k = cyc + 1;
    waitSw(10, a2);
    chk("R5", "entry latency", a2, k + STG);
    chk("R5", "isSlave after entry", int'(isSlave), 1);
    extSync = 1'b0;
    r = a2;

    // R7: following sync edges spaced 60 cycles
    for (int n = 0; n < 4; n++) begin
      cnt0 = swCount;
      repeat (57) @(negedge clk);
      extSync = 1'b1;
      k = cyc + 1;
      waitSw(10, a2);
      chk("R7", "follow latency", a2, k + STG);
      chk("R7", "single pulse per edge", swCount - cnt0, 1);
      extSync = 1'b0;
      r = a2;
    end
    chk("R7", "still slave", int'(isSlave), 1);

    // R8: loss of sync, fallback to master
    waitSw(300, a1);
    chk("R8", "fallback delay", a1 - r, 100 + MARG);
    chk("R8", "isSlave after fallback", int'(isSlave), 0);
    waitSw(120, a2);
    chk("R8", "period after fallback", a2 - a1, 100);
    waitSyncRise(100, rs);
    chk("R8", "sync offset after fallback", rs - a2, 50);

    // R6: no drive while slave
    chk("R6", "syncOut cycles while slave", slaveDrive, 0);

    // R9: own pulse looped back onto syncIn
    doReset(64);
    loopBack = 1'b1;
    waitSw(80, a1);
    for (int n = 0; n < 3; n++) begin
      waitSw(80, a2);
      chk("R9", "period with loopback", a2 - a1, 64);
      a1 = a2;
    end
    chk("R9", "master with loopback", int'(isSlave), 0);
    loopBack = 1'b0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule